// File: doc/BRIEF.md
# Match Timer with Posted Clear

This block is a register-mapped timer with two independent counters driven by a slow timer tick (`tick`, a clock enable in the fast `clk` domain). The event counter is a 32-bit up-counter. It advances on each tick while it is enabled and is compared against a programmable match value. A match raises a one-cycle interrupt pulse and can optionally reset the counter. The timestamp counter is a free-running 32-bit counter that wraps at 2^32. It advances once every 1 to 4 ticks, depending on a prescaler code.

Resetting the event counter is a posted operation. A write to the clear offset raises a pending flag in a status word. While the counter is enabled, the reset takes effect on the third tick after the write, which models the latency of a synchronizer into the slow domain. While the counter is disabled, the reset takes effect on the next cycle. Software polls the flag before it enables the counter again.

Accesses arrive on a request channel that is a valid/ready pair. `req_ready` is always high, so the block never applies back-pressure. A read produces exactly one response beat (`rsp_valid`) in the cycle after it is accepted. The response channel has no ready signal, so the requester must always be able to accept it. Writes produce no response. Offsets are byte addresses, and bits [1:0] are ignored.

Top module: `match_timer`

## Requirements
- R1: After reset: event count 0, match value 0xFFFFFFFF, event control 0, timestamp 0, prescaler code 0, timestamp enable 0, status 0, `irq` low.
- R2: The event count (read at offset 0x04) increases by one on each tick while control bit 0 (offset 0x08) is 1, and holds while that bit is 0.
- R3: When a tick brings the enabled event count equal to the match value (offset 0x00), `irq` is high for exactly one cycle, the cycle after that tick.
- R4: Control bit 1 selects auto-clear. With it set, the count becomes 0 on the matching tick. With it clear, the count takes the match value and keeps counting on later ticks.
- R5: A write of any data to offset 0x0C sets status bit 10 (offset 0x20). While the counter is enabled, the first two ticks after that write still count normally, and the third tick sets the count to 0 and clears bit 10.
- R6: If the counter is disabled while a clear is pending, the count becomes 0 and status bit 10 drops on the next clock.
- R7: A match value written below 4 is stored and read back as 4.
- R8: The timestamp counter (read at offset 0x14) advances once every n+1 ticks, where n is bits [1:0] at offset 0x10, while bit 0 at offset 0x18 is 1. It holds while that bit is 0. A write to offset 0x10 restarts the prescaler phase.
- R9: Reads of unmapped offsets (any offset not listed above) return 0.
- R10: `req_ready` is always 1. A read gives one `rsp_valid` beat on the next cycle, and a write gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| tick | input | 1 | Slow-domain timer enable, one clk cycle per tick |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request ready (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 32 | Read response data |
| irq | output | 1 | Match interrupt pulse |

## Verification
A wrong sync-stage count or pending-flag state shows at the ports as a status bit 10 that drops one tick too early or too late, or as a count that reads nonzero when it should have been cleared. Either is visible within three ticks of the clear write. A broken compare or auto-clear path shows on the first matching tick, as a missing or doubled `irq` pulse or as a count that stays at the match value. A prescaler phase error shows as a timestamp value that is off by one after a handful of ticks.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 6;
  localparam int unsigned WIDX_W   = ADDR_W - 2;
  // word indices of the register offsets
  localparam logic [WIDX_W-1:0] IDX_MATCH = 4'h0; // 0x00
  localparam logic [WIDX_W-1:0] IDX_COUNT = 4'h1; // 0x04
  localparam logic [WIDX_W-1:0] IDX_CTRL  = 4'h2; // 0x08
  localparam logic [WIDX_W-1:0] IDX_CLEAR = 4'h3; // 0x0C
  localparam logic [WIDX_W-1:0] IDX_DIV   = 4'h4; // 0x10
  localparam logic [WIDX_W-1:0] IDX_STAMP = 4'h5; // 0x14
  localparam logic [WIDX_W-1:0] IDX_TSEN  = 4'h6; // 0x18
  localparam logic [WIDX_W-1:0] IDX_STAT  = 4'h8; // 0x20
  localparam int unsigned PEND_BIT = 10;
endpackage

// File: rtl/mt_evt_timer.sv
module mt_evt_timer #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CLR_SYNC  = 3,
  parameter int unsigned MIN_MATCH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_match,
  input  logic              wr_ctrl,
  input  logic              wr_clear,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] match_q,
  output logic [DATA_W-1:0] count_q,
  output logic              en_q,
  output logic              autoclr_q,
  output logic              pend_q,
  output logic              irq_q
);
  localparam int unsigned PCW = (CLR_SYNC > 1) ? $clog2(CLR_SYNC) : 1;
  localparam logic [PCW-1:0] PC_LAST = PCW'(CLR_SYNC - 1);

  logic [PCW-1:0]    pcnt_q;
  logic [DATA_W-1:0] nxt;

  assign nxt = count_q + DATA_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_q   <= '1;
      count_q   <= '0;
      en_q      <= 1'b0;
      autoclr_q <= 1'b0;
      pend_q    <= 1'b0;
      pcnt_q    <= '0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (wr_match)
        match_q <= (wdata < DATA_W'(MIN_MATCH)) ? DATA_W'(MIN_MATCH) : wdata;
      if (wr_ctrl) begin
        en_q      <= wdata[0];
        autoclr_q <= wdata[1];
      end
      if (wr_clear) begin
        pend_q <= 1'b1;
        pcnt_q <= '0;
      end else if (pend_q && !en_q) begin
        pend_q  <= 1'b0;
        count_q <= '0;
      end else if (tick && en_q) begin
        if (pend_q && pcnt_q == PC_LAST) begin
          pend_q  <= 1'b0;
          count_q <= '0;
        end else begin
          if (pend_q) pcnt_q <= pcnt_q + PCW'(1);
          if (nxt == match_q) begin
            irq_q   <= 1'b1;
            count_q <= autoclr_q ? '0 : nxt;
          end else begin
            count_q <= nxt;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mt_ts_counter.sv
module mt_ts_counter #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DIV_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_div,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DIV_W-1:0]  div_q,
  output logic              en_q,
  output logic [DATA_W-1:0] ts_q
);
  logic [DIV_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      en_q  <= 1'b0;
      pre_q <= '0;
      ts_q  <= '0;
    end else begin
      if (wr_en) en_q <= wdata[0];
      if (wr_div) begin
        div_q <= wdata[DIV_W-1:0];
        pre_q <= '0;
      end else if (tick && en_q) begin
        if (pre_q == div_q) begin
          pre_q <= '0;
          ts_q  <= ts_q + DATA_W'(1);
        end else begin
          pre_q <= pre_q + DIV_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/match_timer.sv
module match_timer
  import mt_pkg::*;
#(
  parameter int unsigned CLR_SYNC  = 3,
  parameter int unsigned MIN_MATCH = 4,
  parameter int unsigned DIV_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq
);
  logic [WIDX_W-1:0] widx;
  logic              wr, rd;
  logic [DATA_W-1:0] match_q, count_q, ts_q, rd_mux;
  logic              en_q, autoclr_q, pend_q, ts_en_q;
  logic [DIV_W-1:0]  div_q;

  assign req_ready = 1'b1;
  assign widx      = req_addr[ADDR_W-1:2];
  assign wr        = req_valid && req_write;
  assign rd        = req_valid && !req_write;

  mt_evt_timer #(.DATA_W(DATA_W), .CLR_SYNC(CLR_SYNC), .MIN_MATCH(MIN_MATCH)) u_evt (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .wr_match(wr && widx == IDX_MATCH),
    .wr_ctrl(wr && widx == IDX_CTRL),
    .wr_clear(wr && widx == IDX_CLEAR),
    .wdata(req_wdata),
    .match_q(match_q), .count_q(count_q), .en_q(en_q),
    .autoclr_q(autoclr_q), .pend_q(pend_q), .irq_q(irq)
  );

  mt_ts_counter #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_ts (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .wr_div(wr && widx == IDX_DIV),
    .wr_en(wr && widx == IDX_TSEN),
    .wdata(req_wdata),
    .div_q(div_q), .en_q(ts_en_q), .ts_q(ts_q)
  );

  always_comb begin
    rd_mux = '0;
    case (widx)
      IDX_MATCH: rd_mux = match_q;
      IDX_COUNT: rd_mux = count_q;
      IDX_CTRL:  rd_mux = {{(DATA_W-2){1'b0}}, autoclr_q, en_q};
      IDX_DIV:   rd_mux = {{(DATA_W-DIV_W){1'b0}}, div_q};
      IDX_STAMP: rd_mux = ts_q;
      IDX_TSEN:  rd_mux = {{(DATA_W-1){1'b0}}, ts_en_q};
      IDX_STAT:  rd_mux[PEND_BIT] = pend_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/mt_checker.sv
module mt_checker #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned MIN_MATCH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              irq,
  input logic              pend,
  input logic              en,
  input logic              clr_wr,
  input logic [DATA_W-1:0] count,
  input logic [DATA_W-1:0] match,
  input logic [DATA_W-1:0] ts
);
  assert_irq_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq);
  assert_irq_after_tick_R3: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq) |-> $past(tick && en));
  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n) (!tick && !pend) |=> $stable(count));
  assert_pend_from_write_R5: assert property (@(posedge clk) disable iff (!rst_n) $rose(pend) |-> $past(clr_wr));
  assert_pend_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n) (pend && !en && !clr_wr) |=> (!pend && count == '0));
  assert_match_floor_R7: assert property (@(posedge clk) disable iff (!rst_n) match >= DATA_W'(MIN_MATCH));
  assert_ts_hold_R8: assert property (@(posedge clk) disable iff (!rst_n) !tick |=> $stable(ts));
  assert_ready_R10: assert property (@(posedge clk) disable iff (!rst_n) req_ready);
  assert_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> $past(req_valid && !req_write));
endmodule

bind match_timer mt_checker #(.DATA_W(mt_pkg::DATA_W), .MIN_MATCH(MIN_MATCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .req_valid(req_valid), .req_write(req_write),
  .req_ready(req_ready), .rsp_valid(rsp_valid), .irq(irq), .pend(pend_q), .en(en_q),
  .clr_wr(req_valid && req_write && req_addr[mt_pkg::ADDR_W-1:2] == mt_pkg::IDX_CLEAR),
  .count(count_q), .match(match_q), .ts(ts_q)
);

// File: tb/match_timer_tb_top.sv
`timescale 1ns/1ps
module match_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, irq;
  logic [31:0] rsp_rdata;
  int checks = 0;
  int fails  = 0;
  logic irq_seen;

  always #2.5 clk = ~clk;

  match_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 rsp_valid on read", {31'd0, rsp_valid}, 32'd1);
    d = rsp_rdata;
  endtask

  task automatic ticks(input int n);
    irq_seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      irq_seen = irq_seen | irq;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", {31'd0, irq}, 32'd0);
    rd(6'h00, d); check("R1 match", d, 32'hFFFF_FFFF);
    rd(6'h04, d); check("R1 count", d, 32'd0);
    rd(6'h08, d); check("R1 ctrl", d, 32'd0);
    rd(6'h14, d); check("R1 timestamp", d, 32'd0);
    rd(6'h20, d); check("R1 status", d, 32'd0);
  endtask

  task automatic t_count_match();
    logic [31:0] d;
    wr(6'h00, 32'd10);
    wr(6'h08, 32'd1);
    ticks(5); rd(6'h04, d); check("R2 count after 5 ticks", d, 32'd5);
    wr(6'h08, 32'd0);
    ticks(2); rd(6'h04, d); check("R2 hold while disabled", d, 32'd5);
    wr(6'h08, 32'd1);
    ticks(4); check("R3 no irq before match", {31'd0, irq_seen}, 32'd0);
    ticks(1); check("R3 irq on match", {31'd0, irq_seen}, 32'd1);
    @(negedge clk); check("R3 irq single cycle", {31'd0, irq}, 32'd0);
    rd(6'h04, d); check("R4 count at match value", d, 32'd10);
    ticks(1); rd(6'h04, d); check("R4 counts past match", d, 32'd11);
    check("R3 no second irq", {31'd0, irq_seen}, 32'd0);
  endtask

  task automatic t_clear_enabled();
    logic [31:0] d;
    wr(6'h0C, 32'hDEAD_BEEF);
    rd(6'h20, d); check("R5 pending set", d, 32'h0000_0400);
    ticks(2); rd(6'h04, d); check("R5 counts during sync", d, 32'd13);
    rd(6'h20, d); check("R5 still pending", d, 32'h0000_0400);
    ticks(1); rd(6'h04, d); check("R5 count cleared", d, 32'd0);
    rd(6'h20, d); check("R5 pending dropped", d, 32'd0);
  endtask

  task automatic t_autoclear();
    logic [31:0] d;
    wr(6'h08, 32'd3);
    wr(6'h00, 32'd2);
    rd(6'h00, d); check("R7 match floored", d, 32'd4);
    ticks(3); rd(6'h04, d); check("R4 count before match", d, 32'd3);
    ticks(1); check("R3 irq with auto-clear", {31'd0, irq_seen}, 32'd1);
    rd(6'h04, d); check("R4 auto-clear to zero", d, 32'd0);
  endtask

  task automatic t_clear_disabled();
    logic [31:0] d;
    wr(6'h00, 32'hFFFF_FFFF);
    wr(6'h08, 32'd1);
    ticks(2);
    wr(6'h08, 32'd0);
    wr(6'h0C, 32'd0);
    @(negedge clk);
    rd(6'h20, d); check("R6 pending dropped at once", d, 32'd0);
    rd(6'h04, d); check("R6 count cleared", d, 32'd0);
  endtask

  task automatic t_timestamp();
    logic [31:0] d;
    wr(6'h10, 32'd3);
    wr(6'h18, 32'd1);
    ticks(8); rd(6'h14, d); check("R8 div4", d, 32'd2);
    wr(6'h10, 32'd0);
    ticks(3); rd(6'h14, d); check("R8 div1", d, 32'd5);
    wr(6'h10, 32'd1);
    ticks(5); rd(6'h14, d); check("R8 div2", d, 32'd7);
    wr(6'h10, 32'd2);
    ticks(3); rd(6'h14, d); check("R8 div3", d, 32'd8);
    wr(6'h18, 32'd0);
    ticks(3); rd(6'h14, d); check("R8 hold when disabled", d, 32'd8);
  endtask

  task automatic t_port();
    logic [31:0] d;
    rd(6'h1C, d); check("R9 unmapped 0x1C", d, 32'd0);
    rd(6'h3C, d); check("R9 unmapped 0x3C", d, 32'd0);
    check("R10 ready", {31'd0, req_ready}, 32'd1);
    wr(6'h00, 32'd100);
    check("R10 no response to write", {31'd0, rsp_valid}, 32'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_count_match();
    t_clear_enabled();
    t_autoclear();
    t_clear_disabled();
    t_timestamp();
    t_port();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule